// File: doc/BRIEF.md
# Third-Order Dithered Delta-Sigma Modulator

This block produces the per-cycle fractional correction for a divider whose ratio moves in half steps. It runs on the divided feedback clock. A fractional word of `FRAC_W` bits (23 by default) sits below the half-step bit of the ratio. The block turns it into a short integer sequence whose long-run mean is the fraction. Three first-order accumulators are cascaded. Their carries are combined through a noise-cancelling difference network, which pushes the quantisation error toward high frequencies.

An optional one-bit pseudo-random dither can be added at the least significant bit of the first accumulator. It breaks up the idle tones that appear when the fraction sits close to 0 or close to a whole step.

Each result leaves the block as a 3-bit word on a valid/ready stream. The word is offset by +3, so the signed correction range of -3..+4 fits in 3 unsigned bits. The divider logic removes the offset by subtracting 3 from its base ratio. The modulator takes exactly one step for every word accepted on the stream, so the consumer sets the pace. While `out_valid` is high and `out_ready` is low, the presented word and the internal state are both frozen.

Top module: `dsm_mod3`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_code` is 3. All accumulators, delayed carries and the dither register return to their initial state.
- R2: Starting at the first rising clock edge that samples `rst_n` high, `out_valid` is 1, and it stays 1 until the next reset.
- R3: In a cycle where `out_valid` is high and `out_ready` is low, `out_code` keeps its value and no state advances. The words that follow are the same as if the stall had not happened.
- R4: `out_code` equals the signed correction y plus 3, with y in -3..+4. The first word after reset is 3 (y = 0).
- R5: Each handshake (`out_valid` and `out_ready` both high at a rising edge) performs one modulator step, evaluated in this order:
  - Stage 1 adds `frac` and the dither carry-in to its accumulator. Its carry is c1 and its new residue is r1.
  - Stage 2 adds r1 to its accumulator. Its carry is c2 and its new residue is r2.
  - Stage 3 adds r2 to its accumulator. Its carry is c3.
  - Each sum is taken modulo 2^FRAC_W, and the carries are the overflow bits.
- R6: The word produced by a step is y = c1 + c2 − c2' + c3 − 2·c3' + c3'' + 3. A prime marks the carry of the previous step, a double prime the carry of the step before that, and carries before the first step count as 0. This word is presented after the handshake edge.
- R7: If `frac` is 0 and `dither_en` is 0 at every edge since reset, `out_code` stays 3.
- R8: With dither off and `frac` held constant from reset, take M steps such that `frac`·M is a multiple of 2^FRAC_W. The sum of the M resulting corrections differs from `frac`·M/2^FRAC_W by at most 1.
- R9: The dither source is a FRAC_W-bit shift register seeded all ones.
  - On every handshake it shifts left, taking in bit[FRAC_W−1] XOR bit[LFSR_TAP−1] at bit 0. `LFSR_TAP` is 18 by default.
  - Its bit[FRAC_W−1] is the carry-in of stage 1 when `dither_en` is high, and 0 otherwise.
  - It advances on every handshake whether or not dither is enabled.
- R10: `frac` and `dither_en` are sampled only at handshake edges. A change takes effect in the step of the next handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided feedback clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frac | input | FRAC_W | Fractional word below the half-step bit |
| dither_en | input | 1 | Enables the LSB dither |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | Word available |
| out_code | output | 3 | Correction plus 3 |

## Verification
A stall on the output stream can fall in the same cycle as a change of `frac` or `dither_en`. The bench provokes this by lowering `out_ready` and moving both controls during the stall. It judges the result in two ways. The held word must not move during the stall. The words after the stall must follow a behavioural model in which the new settings apply only from the next accepted step, with the dither register not advanced during the stall. Long runs with random stalls, random fractions and dither toggling are compared against the same model on every clock.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int CODE_W      = 3;
  localparam int CODE_OFFSET = 3;
  localparam int STAGES      = 3;
  typedef logic signed [3:0] corr_t;
endpackage

// File: rtl/dsm_lfsr.sv
module dsm_lfsr #(
  parameter int W   = 23,
  parameter int TAP = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sr_q <= '1;
    else if (step) sr_q <= {sr_q[W-2:0], sr_q[W-1] ^ sr_q[TAP-1]};
  end

  assign bit_o = sr_q[W-1];
endmodule

// File: rtl/dsm_mash_core.sv
module dsm_mash_core
  import dsm_pkg::*;
#(
  parameter int W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [W-1:0]      frac,
  input  logic              cin,
  output logic [STAGES-1:0] carry
);
  logic [STAGES-1:0][W-1:0] resid;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] acc_q;
    logic [W:0]   sum;
    if (k == 0) begin : g_head
      assign sum = {1'b0, acc_q} + {1'b0, frac} + {{W{1'b0}}, cin};
    end else begin : g_tail
      assign sum = {1'b0, acc_q} + {1'b0, resid[k-1]};
    end
    assign resid[k] = sum[W-1:0];
    assign carry[k] = sum[W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (step) acc_q <= resid[k];
    end
  end
endmodule

// File: rtl/dsm_cancel.sv
module dsm_cancel
  import dsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [STAGES-1:0] carry,
  output logic [CODE_W-1:0] code_o
);
  logic  c2_d1, c3_d1, c3_d2;
  corr_t y;
  corr_t y_off;

  always_comb begin
    y = $signed({3'b000, carry[0]})
      + $signed({3'b000, carry[1]}) - $signed({3'b000, c2_d1})
      + $signed({3'b000, carry[2]}) - $signed({2'b00, c3_d1, 1'b0})
      + $signed({3'b000, c3_d2});
    y_off = y + corr_t'(CODE_OFFSET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d1  <= 1'b0;
      c3_d1  <= 1'b0;
      c3_d2  <= 1'b0;
      code_o <= CODE_W'(CODE_OFFSET);
    end else if (step) begin
      c2_d1  <= carry[1];
      c3_d1  <= carry[2];
      c3_d2  <= c3_d1;
      code_o <= y_off[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/dsm_mod3.sv
module dsm_mod3
  import dsm_pkg::*;
#(
  parameter int FRAC_W   = 23,
  parameter int LFSR_TAP = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] frac,
  input  logic              dither_en,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [2:0]        out_code
);
  logic              step;
  logic              dith_bit;
  logic [STAGES-1:0] carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= 1'b1;
  end

  assign step = out_valid & out_ready;

  dsm_lfsr #(.W(FRAC_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(step), .bit_o(dith_bit)
  );

  dsm_mash_core #(.W(FRAC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .frac(frac),
    .cin(dith_bit & dither_en), .carry(carry)
  );

  dsm_cancel u_cancel (
    .clk(clk), .rst_n(rst_n), .step(step), .carry(carry), .code_o(out_code)
  );
endmodule

// File: rtl/dsm_mod3_chk.sv
module dsm_mod3_chk #(
  parameter int FRAC_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FRAC_W-1:0] frac,
  input logic              dither_en,
  input logic              out_ready,
  input logic              out_valid,
  input logic [2:0]        out_code
);
  logic touched_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         touched_q <= 1'b0;
    else if (frac != '0 || dither_en)   touched_q <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (out_code == 3'd3 && !out_valid));

  assert_valid_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> out_valid);

  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_code));

  assert_step_only_on_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> $stable(out_code));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !touched_q |-> out_code == 3'd3);
endmodule

bind dsm_mod3 dsm_mod3_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frac(frac), .dither_en(dither_en),
  .out_ready(out_ready), .out_valid(out_valid), .out_code(out_code)
);

// File: tb/test_dsm_mod3.sv
module test_dsm_mod3;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 23;
  localparam longint MOD = 64'd1 << FW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [FW-1:0] frac = '0;
  logic          dither_en = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [2:0]    out_code;

  int total = 0;
  int bad = 0;

  longint a1, a2, a3;
  int c2d, c3d, c3dd, m_code;
  bit m_valid;
  logic [FW-1:0] m_lf;

  dsm_mod3 i_dsm_mod3 (
    .clk(clk), .rst_n(rst_n), .frac(frac), .dither_en(dither_en),
    .out_ready(out_ready), .out_valid(out_valid), .out_code(out_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    longint s;
    int c1, c2, c3, d;
    if (!rst_n) begin
      a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0;
      m_code = 3; m_valid = 0; m_lf = '1;
    end else begin
      if (m_valid && out_ready) begin
        d  = (dither_en && m_lf[FW-1]) ? 1 : 0;
        s  = a1 + longint'(frac) + d;     c1 = int'(s / MOD); a1 = s % MOD;
        s  = a2 + a1;                     c2 = int'(s / MOD); a2 = s % MOD;
        s  = a3 + a2;                     c3 = int'(s / MOD); a3 = s % MOD;
        m_code = c1 + c2 - c2d + c3 - 2*c3d + c3dd + 3;
        c3dd = c3d; c3d = c3; c2d = c2;
        m_lf = {m_lf[FW-2:0], m_lf[FW-1] ^ m_lf[17]};
      end
      m_valid = 1;
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), int'(m_valid));
    check(req, int'(out_code), m_code);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) cyc("R1 reset");
    check("R1 reset code", int'(out_code), 3);
    check("R1 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    cyc("R2 first edge");
    check("R2 valid high", int'(out_valid), 1);
  endtask

  task automatic sum_run(input string req, input logic [FW-1:0] f, input int m, input int exp);
    int acc, n, err;
    do_reset();
    frac = f; dither_en = 1'b0; out_ready = 1'b1;
    acc = 0; n = 0;
    while (n < m + 1) begin
      if (out_valid && out_ready) begin
        acc += int'(out_code) - 3;
        n++;
      end
      cyc("R5 R6 sum run");
    end
    err = acc - exp;
    if (err > 1 || err < -1) check(req, acc, exp);
    else                     check(req, exp, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] held;
    #1;
    // R1, R2, R7: idle input keeps the zero correction
    do_reset();
    check("R4 first word", int'(out_code), 3);
    out_ready = 1'b1;
    for (int i = 0; i < 200; i++) cyc("R7 idle");
    check("R7 idle code", int'(out_code), 3);

    // R8: mean equals the fraction over whole periods
    sum_run("R8 mean 3/8",        23'(3 << 20),          64,   24);
    sum_run("R8 mean small",      23'(5 << 13),          1024, 5);
    sum_run("R8 mean near one",   23'(MOD - (1 << 13)),  1024, 1023);
    sum_run("R8 mean half",       23'(1 << 22),          16,   8);

    // R3, R10: stall coinciding with changes of fraction and dither
    do_reset();
    frac = 23'h12345; out_ready = 1'b1;
    for (int i = 0; i < 20; i++) cyc("R5 R6 pre-stall");
    out_ready = 1'b0;
    held = out_code;
    for (int i = 0; i < 6; i++) begin
      frac = 23'($urandom);
      dither_en = ~dither_en;
      cyc("R3 R10 stall");
      check("R3 held word", int'(out_code), int'(held));
    end
    out_ready = 1'b1;
    for (int i = 0; i < 40; i++) cyc("R9 R10 post-stall");

    // R9: fraction at all ones with dither on, near-one spur case
    do_reset();
    frac = '1; dither_en = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < 300; i++) cyc("R9 near-one dither");
    frac = 23'd1;
    for (int i = 0; i < 300; i++) cyc("R9 near-zero dither");

    // R3 R4 R5 R6 R9 R10: random stalls, fractions and dither
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      out_ready = ($urandom % 4) != 0;
      if ($urandom % 64 == 0) frac = 23'($urandom);
      if ($urandom % 300 == 0) dither_en = ~dither_en;
      cyc("R3 R4 R5 R6 R9 R10 random");
    end

    // R1: reset in the middle of activity
    rst_n = 1'b0;
    cyc("R1 mid reset");
    check("R1 mid reset code", int'(out_code), 3);
    rst_n = 1'b1;
    cyc("R2 after mid reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule